// File: doc/BRIEF.md
# Double-Buffered Timer Compare Unit

This block pairs an 8-bit up counter with an 8-bit compare value and raises a one-cycle match pulse when the two agree. The compare value has two stages. A write buffer takes every bus write. An active register feeds the comparator. A buffer-enable bit selects the write path. When the bit is clear, a write lands in both stages at once. When the bit is set, a write lands only in the buffer. The buffer then moves into the active register on a trigger that depends on the counting mode.

There are three counting modes. In the interval mode the counter restarts after each match. In the PWM mode the counter runs over a period of 2^n counts. In the PPG mode the counter runs over the full 8-bit range, and each roll from FFh to 00h starts a new cycle. An active compare value of zero does not mean "match at count zero". It means "match on counter overflow". A small state machine tracks the running mode and holds one restart cycle whenever the mode changes.

The states are ST_RESTART, ST_RUN_IV, ST_RUN_PWM and ST_RUN_PPG. The transitions are:
- Reset enters ST_RESTART.
- ST_RESTART always moves to the run state that matches mode_sel.
- Any run state whose mode no longer matches mode_sel moves to ST_RESTART.
- Otherwise a run state stays where it is.

Top module: `tcu_compare_unit`

## Requirements
- R1: In the interval mode (mode_sel 2'b00, or the unused code 2'b11), the counter clears on the cycle after it equals a nonzero active compare value C. Pulses therefore repeat every C+1 cycles.
- R2: When the active compare value is 00h, a match is flagged on counter overflow instead of on equality. Overflow is count FFh in the interval and PPG modes, and the top count of the 2^n period in the PWM mode. This gives a 256-cycle interval period.
- R3: With buffer-enable clear, a write (wr_en high) loads wr_data into both the buffer and the active compare register at the same clock edge.
- R4: With buffer-enable set, a write loads only the buffer. The interval mode has no transfer trigger, so such writes never change the match timing there.
- R5: Synchronous reset (rst high) clears the buffer-enable bit, the counter, the buffer and the active compare register, and holds match_pulse low.
- R6: In the PWM mode (mode_sel 2'b01) with buffer-enable set, the buffer is copied into the active register at the 2^n overflow. The new value takes effect from the next period.
- R7: In the PPG mode (mode_sel 2'b10) with buffer-enable set, the buffer is copied into the active register when the counter rolls from FFh to 00h, which starts each PPG cycle.
- R8: pwm_n values 6, 7 and 8 give a PWM period of 2^n cycles, with the counter clearing after its low n bits are all ones. Any other pwm_n value behaves as 8.
- R9: match_pulse is registered. It is high for exactly the one cycle that follows the cycle in which the counter met the match condition.
- R10: If a write and a transfer trigger fall in the same cycle, the active register takes the old buffer contents and the written data stays in the buffer.
- R11: A change of mode_sel puts the block through one ST_RESTART cycle. During that cycle the counter is zero and no match is flagged. Counting then starts from zero in the new mode, so the first match on value C appears C+3 cycles after the cycle in which the new mode is driven.
- R12: The buffer-enable bit is written through ctl_wr and ctl_buf_en. A data write in the same cycle uses the old bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Compare value write strobe |
| wr_data | input | 8 | Compare value write data |
| ctl_wr | input | 1 | Buffer-enable bit write strobe |
| ctl_buf_en | input | 1 | New value of the buffer-enable bit |
| mode_sel | input | 2 | 00 interval, 01 PWM, 10 PPG, 11 interval |
| pwm_n | input | 4 | PWM period exponent (6, 7 or 8) |
| match_pulse | output | 1 | One-cycle match-detect pulse |

## Verification
A bus write can land in the very cycle where the overflow trigger copies the buffer into the active register. The bench provokes this in the PWM mode with n = 6. It locates the counter from a known match pulse, counts forward to the last count of the period, and drives the write in exactly that cycle. The outcome is judged from the spacing of the next two pulses, 56 and then 104 cycles. A design that let the new data pass straight through would show a 96-cycle gap instead.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    typedef enum logic [1:0] {
        MODE_IV  = 2'b00,
        MODE_PWM = 2'b01,
        MODE_PPG = 2'b10,
        MODE_RSV = 2'b11
    } tcu_mode_e;

    typedef enum logic [1:0] {
        ST_RESTART = 2'd0,
        ST_RUN_IV  = 2'd1,
        ST_RUN_PWM = 2'd2,
        ST_RUN_PPG = 2'd3
    } tcu_state_e;

    function automatic tcu_state_e mode_to_state(input logic [1:0] m);
        tcu_state_e s;
        case (m)
            MODE_PWM: s = ST_RUN_PWM;
            MODE_PPG: s = ST_RUN_PPG;
            default:  s = ST_RUN_IV;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/tcu_cmp_regs.sv
module tcu_cmp_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ctl_wr,
    input  logic             ctl_buf_en,
    input  logic             xfer,
    output logic             buf_en_q,
    output logic [CNT_W-1:0] active_q
);

    logic [CNT_W-1:0] buffer_q;

    // buffer-enable control bit
    always_ff @(posedge clk) begin
        if (rst)         buf_en_q <= 1'b0;
        else if (ctl_wr) buf_en_q <= ctl_buf_en;
    end

    // write buffer: every write lands here
    always_ff @(posedge clk) begin
        if (rst)        buffer_q <= '0;
        else if (wr_en) buffer_q <= wr_data;
    end

    // active compare register: transfer takes the old buffer value
    always_ff @(posedge clk) begin
        if (rst)                       active_q <= '0;
        else if (xfer)                 active_q <= buffer_q;
        else if (wr_en && !buf_en_q)   active_q <= wr_data;
    end

    assert_unbuf_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !buf_en_q) |=> (active_q == $past(wr_data) && buffer_q == $past(wr_data)));

    assert_buf_write_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && buf_en_q && !xfer) |=> (active_q == $past(active_q)));

    assert_xfer_old_buffer_R10: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (active_q == $past(buffer_q)));

    assert_reset_clear_R5: assert property (@(posedge clk)
        $past(rst) |-> (!buf_en_q && active_q == '0 && buffer_q == '0));

endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
    parameter int CNT_W = 8,
    parameter int N_W   = 4,
    parameter int N_MIN = 6,
    parameter int N_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             pwm_sel,
    input  logic [N_W-1:0]   pwm_n,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);

    localparam logic [N_W-1:0] N_LO  = N_W'(N_MIN);
    localparam logic [N_W-1:0] N_HI  = N_W'(N_MAX);
    localparam logic [N_W-1:0] N_DEF = N_W'(CNT_W);

    logic [N_W-1:0]   n_eff;
    logic [CNT_W:0]   lim_wide;
    logic [CNT_W-1:0] mask;

    always_comb begin
        n_eff    = ((pwm_n >= N_LO) && (pwm_n <= N_HI)) ? pwm_n : N_DEF;
        lim_wide = ((CNT_W+1)'(1) << n_eff) - (CNT_W+1)'(1);
        mask     = pwm_sel ? lim_wide[CNT_W-1:0] : {CNT_W{1'b1}};
        ovf      = ((cnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst)                 cnt_q <= '0;
        else if (clr)            cnt_q <= '0;
        else if (pwm_sel && ovf) cnt_q <= '0;
        else                     cnt_q <= cnt_q + CNT_W'(1);
    end

    assert_pwm_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        (pwm_sel && ovf) |=> (cnt_q == '0));

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/tcu_ctrl_fsm.sv
module tcu_ctrl_fsm
    import tcu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_sel,
    input  logic       buf_en_q,
    input  logic       ovf,
    input  logic       cnt_eq,
    input  logic       cmp_zero,
    output tcu_state_e state_q,
    output logic       cnt_clr,
    output logic       pwm_sel,
    output logic       xfer,
    output logic       match_pulse
);

    tcu_state_e target;
    tcu_state_e state_d;
    logic       mode_chg;
    logic       hit;

    always_comb begin
        target   = mode_to_state(mode_sel);
        mode_chg = (state_q != ST_RESTART) && (state_q != target);
        unique case (state_q)
            ST_RESTART: state_d = target;
            ST_RUN_IV:  state_d = mode_chg ? ST_RESTART : ST_RUN_IV;
            ST_RUN_PWM: state_d = mode_chg ? ST_RESTART : ST_RUN_PWM;
            ST_RUN_PPG: state_d = mode_chg ? ST_RESTART : ST_RUN_PPG;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_RESTART;
        else     state_q <= state_d;
    end

    // control decode for the datapath
    always_comb begin
        pwm_sel = (state_q == ST_RUN_PWM);
        hit     = !mode_chg && (state_q != ST_RESTART) && (cmp_zero ? ovf : cnt_eq);
        cnt_clr = (state_q == ST_RESTART) || mode_chg || ((state_q == ST_RUN_IV) && hit);
        xfer    = 1'b0;
        unique case (state_q)
            ST_RESTART: xfer = 1'b0;
            ST_RUN_IV:  xfer = 1'b0;
            ST_RUN_PWM: xfer = buf_en_q && ovf && !mode_chg;
            ST_RUN_PPG: xfer = buf_en_q && ovf && !mode_chg;
        endcase
    end

    // registered match output
    always_ff @(posedge clk) begin
        if (rst) match_pulse <= 1'b0;
        else     match_pulse <= hit;
    end

    assert_restart_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESTART) |=> (state_q != ST_RESTART));

    assert_restart_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESTART) |=> !match_pulse);

endmodule

// File: rtl/tcu_compare_unit.sv
module tcu_compare_unit
    import tcu_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int N_W   = 4,
    parameter int N_MIN = 6,
    parameter int N_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ctl_wr,
    input  logic             ctl_buf_en,
    input  logic [1:0]       mode_sel,
    input  logic [N_W-1:0]   pwm_n,
    output logic             match_pulse
);

    tcu_state_e       state_q;
    logic             cnt_clr;
    logic             pwm_sel;
    logic             xfer;
    logic             buf_en_q;
    logic [CNT_W-1:0] active_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf;
    logic             cnt_eq;
    logic             cmp_zero;

    assign cnt_eq   = (cnt_q == active_q);
    assign cmp_zero = (active_q == '0);

    tcu_ctrl_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .mode_sel    (mode_sel),
        .buf_en_q    (buf_en_q),
        .ovf         (ovf),
        .cnt_eq      (cnt_eq),
        .cmp_zero    (cmp_zero),
        .state_q     (state_q),
        .cnt_clr     (cnt_clr),
        .pwm_sel     (pwm_sel),
        .xfer        (xfer),
        .match_pulse (match_pulse)
    );

    tcu_counter #(
        .CNT_W (CNT_W),
        .N_W   (N_W),
        .N_MIN (N_MIN),
        .N_MAX (N_MAX)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (cnt_clr),
        .pwm_sel (pwm_sel),
        .pwm_n   (pwm_n),
        .cnt_q   (cnt_q),
        .ovf     (ovf)
    );

    tcu_cmp_regs #(
        .CNT_W (CNT_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .ctl_wr     (ctl_wr),
        .ctl_buf_en (ctl_buf_en),
        .xfer       (xfer),
        .buf_en_q   (buf_en_q),
        .active_q   (active_q)
    );

    assert_restart_cnt_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESTART) |-> (cnt_q == '0));

    assert_iv_no_transfer_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN_IV && buf_en_q && !ctl_wr) |=> (active_q == $past(active_q)));

    assert_ppg_xfer_at_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RUN_PPG && buf_en_q && cnt_q == {CNT_W{1'b1}} && mode_sel == 2'b10)
        |=> (cnt_q == '0));

endmodule

// File: tb/tcu_compare_unit_bench.sv
module tcu_compare_unit_bench;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       ctl_wr = 1'b0;
    logic       ctl_buf_en = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic [3:0] pwm_n = 4'd8;
    logic       match_pulse;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    tcu_compare_unit u_tcu_compare_unit (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .ctl_wr      (ctl_wr),
        .ctl_buf_en  (ctl_buf_en),
        .mode_sel    (mode_sel),
        .pwm_n       (pwm_n),
        .match_pulse (match_pulse)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int t);
        int k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!match_pulse && k < 3000);
        if (!match_pulse) check(1'b0, "pulse timeout", k, 0);
        t = cyc;
    endtask

    task automatic gap_check(input string req, input int exp);
        int t1, t2;
        wait_pulse(t1);
        wait_pulse(t2);
        check((t2 - t1) == exp, req, t2 - t1, exp);
    endtask

    task automatic wr_cmp(input logic [7:0] v);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_buf(input logic b);
        ctl_wr = 1'b1; ctl_buf_en = b;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic do_reset;
        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(match_pulse == 1'b0, "R5 reset holds match low", match_pulse, 0);
        end
        rst = 1'b0;
    endtask

    // R5, R2: fresh reset, zero compare means overflow every 256
    task automatic t_reset_state;
        mode_sel = 2'b00;
        do_reset();
        gap_check("R5 R2 zero compare after reset, overflow period", 256);
    endtask

    // R1, R3, R9: unbuffered interval writes
    task automatic t_interval;
        int t;
        wr_cmp(8'd10);
        gap_check("R1 R3 interval period C+1", 11);
        wait_pulse(t);
        @(negedge clk);
        check(match_pulse == 1'b0, "R9 pulse lasts one cycle", match_pulse, 0);
        mode_sel = 2'b11;
        gap_check("R1 unused mode code acts as interval", 11);
        mode_sel = 2'b00;
    endtask

    // R11: restart latency after a mode change
    task automatic t_restart;
        int t0, t1;
        wait_pulse(t0);
        pwm_n = 4'd8;
        mode_sel = 2'b01;
        t0 = cyc;
        wait_pulse(t1);
        check((t1 - t0) == 13, "R11 first match C+3 after mode change", t1 - t0, 13);
        gap_check("R8 PWM n=8 period", 256);
    endtask

    // R4, R12: buffered writes ignored in interval mode
    task automatic t_iv_buffered;
        mode_sel = 2'b00;
        set_buf(1'b1);
        wr_cmp(8'd20);
        gap_check("R4 buffered write has no effect in interval", 11);
        gap_check("R4 interval still unchanged later", 11);
        // R12: control and data write in one cycle use the old bit
        ctl_wr = 1'b1; ctl_buf_en = 1'b0;
        wr_en = 1'b1; wr_data = 8'd30;
        @(negedge clk);
        ctl_wr = 1'b0; wr_en = 1'b0;
        gap_check("R12 same-cycle write used old buffer-enable", 11);
        wr_cmp(8'd4);
        gap_check("R12 buffer-enable now clear, write immediate", 5);
    endtask

    // R8: PWM periods for each exponent
    task automatic t_pwm_periods;
        mode_sel = 2'b01;
        wr_cmp(8'd5);
        pwm_n = 4'd6;
        gap_check("R8 PWM n=6 period", 64);
        pwm_n = 4'd7;
        gap_check("R8 PWM n=7 period", 128);
        pwm_n = 4'd3;
        gap_check("R8 PWM illegal n behaves as 8", 256);
        pwm_n = 4'd6;
    endtask

    // R6: buffered PWM transfer at 2^n overflow
    task automatic t_pwm_xfer;
        int t1, t2;
        wr_cmp(8'h10);
        wait_pulse(t1);
        set_buf(1'b1);
        wr_cmp(8'h30);
        wait_pulse(t2);
        check((t2 - t1) == 96, "R6 PWM transfer waits for overflow", t2 - t1, 96);
        gap_check("R6 PWM new value steady", 64);
    endtask

    // R10: write in the same cycle as the transfer trigger
    task automatic t_collision;
        int t0, t1, t2;
        set_buf(1'b0);
        wr_cmp(8'h10);
        wait_pulse(t0);          // counter now 0x11
        set_buf(1'b1);           // counter 0x12
        wr_cmp(8'h08);           // counter 0x13
        repeat (44) @(negedge clk);
        wr_cmp(8'h30);           // lands on count 0x3F
        wait_pulse(t1);
        check((t1 - t0) == 56, "R10 transfer takes old buffer", t1 - t0, 56);
        wait_pulse(t2);
        check((t2 - t1) == 104, "R10 new data waits in buffer", t2 - t1, 104);
    endtask

    // R7: PPG transfer at cycle start
    task automatic t_ppg_xfer;
        int t1, t2;
        mode_sel = 2'b10;
        set_buf(1'b0);
        wr_cmp(8'h40);
        wait_pulse(t1);
        set_buf(1'b1);
        wr_cmp(8'h80);
        wait_pulse(t2);
        check((t2 - t1) == 320, "R7 PPG transfer at cycle start", t2 - t1, 320);
        gap_check("R7 PPG steady period", 256);
    endtask

    // R5: reset clears the buffer-enable bit mid-run
    task automatic t_reset_midrun;
        mode_sel = 2'b00;
        do_reset();
        wr_cmp(8'd7);
        gap_check("R5 reset cleared buffer-enable, write immediate", 8);
    endtask

    initial begin
        t_reset_state();
        t_interval();
        t_restart();
        t_iv_buffered();
        t_pwm_periods();
        t_pwm_xfer();
        t_collision();
        t_ppg_xfer();
        t_reset_midrun();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule